// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block lets a synchronous host reach an external 64K x 4 asynchronous static RAM. The host issues one read or write at a time over a valid/ready request channel. The controller turns each request into a correctly timed strobe sequence on the memory pins: active-low chip enable, active-low write enable, address, and a split data bus with an output enable for the pad tristate. It finishes each access with a one-cycle response pulse.

Every memory timing limit is given in picoseconds together with the clock period. The controller rounds each limit up to whole clock cycles at elaboration. From those counts it places:

- the write-enable pulse,
- the point where it starts driving the bus after the memory's output turn-off window,
- the data setup before the write ends,
- the address hold after it,
- the read sampling point.

A level-sensitive retention request parks the memory in standby with chip enable high. The controller then reports when supply reduction is safe. After the request is released, it holds chip enable high for one read-cycle time before it accepts new work.

Back-pressure: a request is held on `req_*` until `req_ready` is seen high at a rising edge; the transfer happens on that edge. The response channel has no back-pressure: `rsp_valid` is a single-cycle pulse that the host must take when it appears.

Top module: `sram_ctl`

## Requirements
- R1: After reset, chip enable and write enable are high, the data output enable is low, the retention acknowledge is low and `req_ready` is high.
- R2: A write holds chip enable and write enable low together for exactly WE_LEN = max(T_WP, T_TURN + T_DS) cycles, where T_WP is the write pulse width in cycles. Both then rise in the same cycle. Write enable is never low while chip enable is high.
- R3: The data output enable first rises T_TURN cycles after write enable falls. It is never high while chip enable is low and write enable is high (a read).
- R4: Write data is driven and stable for at least T_DS cycles before write enable rises. It stays driven for the T_AH address-hold cycles that follow.
- R5: A read holds chip enable low with write enable high for T_RD cycles. It samples `mem_dq_i` at the last rising edge of that window and returns the sample on `rsp_rdata` in the next cycle.
- R6: `req_ready` is high only when the controller is idle and no retention is requested. `rsp_valid` is a one-cycle pulse. It appears WE_LEN + T_AH cycles after a write is accepted and T_RD + 1 cycles after a read is accepted.
- R7: `mem_addr` equals the accepted request address and stays constant while chip enable is low and through the hold cycles of a write.
- R8: When `ret_req` is high while idle, it takes priority over a pending request. `ret_ack` then rises one cycle later, with chip enable already high in the cycle before.
- R9: After `ret_req` falls, chip enable stays high and no request is accepted for T_REC cycles. `req_ready` returns on the cycle after.
- R10: Each cycle count is the picosecond limit divided by the clock period, rounded up, with a minimum of one. With the defaults (4000 ps clock) this gives T_RD = T_REC = 4, T_WP = 3, T_TURN = 2, T_DS = 2, T_AH = 1 and WE_LEN = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read data, valid with rsp_valid after a read |
| ret_req | input | 1 | Level request to enter data retention |
| ret_ack | output | 1 | Memory parked, supply may be reduced |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 16 | Memory address |
| mem_dq_o | output | 4 | Data toward the memory |
| mem_dq_oe | output | 1 | Output enable for the data pad driver |
| mem_dq_i | input | 4 | Data from the memory pads |

## Verification
The bench memory model returns the inverted word until the read strobe has lasted T_RD cycles. A controller that samples one edge early therefore returns wrong read data rather than a lucky match. At every write-enable rising edge, the pin monitor measures:

- the pulse length, where a short pulse shows the setup/turnaround sum was ignored;
- the cycle at which the bus driver turned on, where an early driver collides with the memory's own outputs;
- the data setup, where data that changes late lands the wrong word in the model.

Retention priority over a waiting request, the exact recovery length, and back-to-back mixed traffic are also targeted. A controller that shortens recovery or accepts work while parked shows up as a wrong `req_ready` count or an unexpected access.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RD_ACCESS,
    ST_RD_DONE,
    ST_RETAIN,
    ST_RECOVER
  } ctl_state_t;

  // Round a picosecond limit up to whole clock cycles, at least one.
  function automatic int unsigned ps_to_cycles(input int unsigned lim_ps,
                                               input int unsigned clk_ps);
    int unsigned c;
    c = (lim_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned WE_LEN = 4,
  parameter int unsigned AH_CYC = 1,
  parameter int unsigned RD_CYC = 4,
  parameter int unsigned REC_CYC = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             ret_req,
  output ctl_state_t       state,
  output logic [CNT_W-1:0] cnt,
  output logic             accept,
  output logic             capture,
  output logic             req_ready,
  output logic             rsp_valid
);

  localparam logic [CNT_W-1:0] WE_LAST  = CNT_W'(WE_LEN - 1);
  localparam logic [CNT_W-1:0] AH_LAST  = CNT_W'(AH_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);

  ctl_state_t state_d;
  logic       last;

  always_comb begin
    unique case (state)
      ST_WR_PULSE:  last = (cnt == WE_LAST);
      ST_WR_HOLD:   last = (cnt == AH_LAST);
      ST_RD_ACCESS: last = (cnt == RD_LAST);
      ST_RECOVER:   last = (cnt == REC_LAST);
      default:      last = 1'b1;
    endcase
  end

  assign req_ready = (state == ST_IDLE) && !ret_req;
  assign accept    = req_ready && req_valid;
  assign capture   = (state == ST_RD_ACCESS) && last;
  assign rsp_valid = ((state == ST_WR_HOLD) && last) || (state == ST_RD_DONE);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: begin
        if (ret_req)        state_d = ST_RETAIN;
        else if (req_valid) state_d = req_write ? ST_WR_PULSE : ST_RD_ACCESS;
      end
      ST_WR_PULSE:  if (last) state_d = ST_WR_HOLD;
      ST_WR_HOLD:   if (last) state_d = ST_IDLE;
      ST_RD_ACCESS: if (last) state_d = ST_RD_DONE;
      ST_RD_DONE:   state_d = ST_IDLE;
      ST_RETAIN:    if (!ret_req) state_d = ST_RECOVER;
      ST_RECOVER:   if (last) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_d;
      if (state_d != state) cnt <= '0;
      else if (state == ST_IDLE || state == ST_RETAIN) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 4,
  parameter int unsigned TURN_CYC = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_state_t        state,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ret_ack,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);

  localparam logic [CNT_W-1:0] TURN_C = CNT_W'(TURN_CYC);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= mem_dq_i;
    end
  end

  // Strobes decode from the state flops only.
  assign mem_ce_n  = !((state == ST_WR_PULSE) || (state == ST_RD_ACCESS));
  assign mem_we_n  = (state != ST_WR_PULSE);
  assign mem_dq_oe = ((state == ST_WR_PULSE) && (cnt >= TURN_C)) ||
                     (state == ST_WR_HOLD);
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign rsp_rdata = rdata_q;
  assign ret_ack   = (state == ST_RETAIN);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 4,
  parameter int unsigned CLK_PS  = 4000,
  parameter int unsigned RC_PS   = 15000,
  parameter int unsigned WP_PS   = 12000,
  parameter int unsigned TURN_PS = 7000,
  parameter int unsigned DS_PS   = 7000,
  parameter int unsigned AH_PS   = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ret_req,
  output logic              ret_ack,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned RD_CYC   = ps_to_cycles(RC_PS, CLK_PS);
  localparam int unsigned REC_CYC  = RD_CYC;
  localparam int unsigned WP_CYC   = ps_to_cycles(WP_PS, CLK_PS);
  localparam int unsigned TURN_CYC = ps_to_cycles(TURN_PS, CLK_PS);
  localparam int unsigned DS_CYC   = ps_to_cycles(DS_PS, CLK_PS);
  localparam int unsigned AH_CYC   = ps_to_cycles(AH_PS, CLK_PS);
  localparam int unsigned WE_LEN   = (WP_CYC > TURN_CYC + DS_CYC) ? WP_CYC
                                                                  : TURN_CYC + DS_CYC;
  localparam int unsigned MAX_LEN  = (WE_LEN > RD_CYC) ? WE_LEN : RD_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1);

  ctl_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             capture;

  sram_ctl_fsm #(
    .WE_LEN(WE_LEN), .AH_CYC(AH_CYC), .RD_CYC(RD_CYC),
    .REC_CYC(REC_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .ret_req(ret_req), .state(state), .cnt(cnt), .accept(accept),
    .capture(capture), .req_ready(req_ready), .rsp_valid(rsp_valid)
  );

  sram_ctl_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TURN_CYC(TURN_CYC), .CNT_W(CNT_W)
  ) u_pins (
    .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt), .accept(accept),
    .capture(capture), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_dq_i(mem_dq_i), .rsp_rdata(rsp_rdata), .ret_ack(ret_ack),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 4,
  parameter int unsigned WE_LEN   = 4,
  parameter int unsigned TURN_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              ret_ack,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);

  int unsigned we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_low_cnt <= 0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1;
    else we_low_cnt <= 0;
  end

  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R2
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == WE_LEN) && mem_ce_n); // R2
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_ce_n && mem_we_n)); // R3
  AST_DRIVE_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> !mem_we_n && (we_low_cnt >= TURN_CYC)); // R3
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe && $past(mem_dq_oe) |-> $stable(mem_dq_o)); // R4
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_READY_ONLY_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n && mem_we_n && !ret_ack); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n && $past(!mem_ce_n) |-> $stable(mem_addr)); // R7
  AST_RET_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ret_ack) |-> mem_ce_n && $past(mem_ce_n)); // R8

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_LEN(WE_LEN), .TURN_CYC(TURN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ret_ack(ret_ack), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
  .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

  localparam int CLK_PS = 4000;
  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int T_RD = cyc(15000);
  localparam int T_REC = T_RD;
  localparam int T_WP = cyc(12000);
  localparam int T_TURN = cyc(7000);
  localparam int T_DS = cyc(7000);
  localparam int T_AH = cyc(2000);
  localparam int WE_LEN = (T_WP > T_TURN + T_DS) ? T_WP : T_TURN + T_DS;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0, ret_req = 0;
  logic [15:0] req_addr = '0;
  logic [3:0] req_wdata = '0, mem_dq_i = '0;
  logic req_ready, rsp_valid, ret_ack, mem_ce_n, mem_we_n, mem_dq_oe;
  logic [3:0] rsp_rdata, mem_dq_o;
  logic [15:0] mem_addr;

  always #2 clk = ~clk;

  sram_ctl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ret_req(ret_req),
    .ret_ack(ret_ack), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int checks = 0, errors = 0;
  logic [3:0] model_mem [256];
  logic [3:0] exp_mem [256];
  logic [15:0] exp_addr = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pin-level memory model and write-timing monitor.
  int we_low = 0, oe_first = -1, ds_cnt = 0, rd_cnt = 0;
  logic prev_we = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n) begin
        if (mem_dq_oe && oe_first < 0) oe_first = we_low;
        if (mem_dq_oe) ds_cnt++;
        we_low++;
      end else if (!prev_we) begin
        chk(we_low == WE_LEN, "R2 we pulse cycles", we_low, WE_LEN);
        chk(mem_ce_n == 1'b1, "R2 ce rises with we", mem_ce_n, 1);
        chk(oe_first == T_TURN, "R3 drive start", oe_first, T_TURN);
        chk(ds_cnt >= T_DS && mem_dq_oe, "R4 data setup/hold", ds_cnt, T_DS);
        chk(mem_addr == exp_addr, "R7 write address", mem_addr, exp_addr);
        model_mem[mem_addr[7:0]] = mem_dq_o;
        we_low = 0; oe_first = -1; ds_cnt = 0;
      end
      prev_we = mem_we_n;
      if (!mem_ce_n && mem_we_n) begin
        rd_cnt++;
        if (rd_cnt == 1) chk(mem_addr == exp_addr, "R7 read address", mem_addr, exp_addr);
      end else rd_cnt = 0;
      mem_dq_i = (rd_cnt >= T_RD) ? model_mem[mem_addr[7:0]] : ~model_mem[mem_addr[7:0]];
    end
  end

  function automatic int exp_lat(input bit w);
    return w ? WE_LEN + T_AH : T_RD + 1;
  endfunction

  task automatic do_op(input bit w, input logic [15:0] a, input logic [3:0] d);
    int lat;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_addr = a;
    if (w) exp_mem[a[7:0]] = d;
    lat = 0;
    do begin
      @(negedge clk);
      req_valid = 0;
      lat++;
      if (lat == 1) chk(!req_ready, "R6 busy not ready", req_ready, 0);
    end while (!rsp_valid && lat < 40);
    chk(lat == exp_lat(w), w ? "R6 R10 write latency" : "R5 R10 read latency",
        lat, exp_lat(w));
    if (!w) chk(rsp_rdata == exp_mem[a[7:0]], "R5 read data", rsp_rdata, exp_mem[a[7:0]]);
    @(negedge clk);
    chk(!rsp_valid, "R6 rsp one cycle", rsp_valid, 0);
  endtask

  task automatic retention(input bit with_req);
    int n;
    @(negedge clk);
    ret_req = 1;
    if (with_req) begin req_valid = 1; req_write = 0; req_addr = 16'h0042; end
    @(negedge clk);
    chk(ret_ack == 1'b1, "R8 ret_ack after one cycle", ret_ack, 1);
    chk(mem_ce_n == 1'b1 && rd_cnt == 0, "R8 retention wins, ce high", mem_ce_n, 1);
    repeat (5) @(negedge clk);
    chk(ret_ack && mem_ce_n && !req_ready, "R8 parked", req_ready, 0);
    ret_req = 0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!mem_ce_n) chk(0, "R9 ce low in recovery", 0, 1);
    end while (!req_ready && n < 40);
    chk(n == T_REC + 1, "R9 recovery length", n, T_REC + 1);
    if (with_req) begin
      exp_addr = 16'h0042;
      @(negedge clk);
      req_valid = 0;
      n = 0;
      do begin @(negedge clk); n++; end while (!rsp_valid && n < 40);
      chk(rsp_rdata == exp_mem[8'h42], "R8 held request served later", rsp_rdata, exp_mem[8'h42]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin model_mem[i] = 4'h0; exp_mem[i] = 4'h0; end
    void'($urandom(32'h5EED_0C7A));
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && !mem_dq_oe && !ret_ack, "R1 pins in reset",
        {mem_ce_n, mem_we_n, mem_dq_oe, ret_ack}, 4'b1100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    // Directed corners
    do_op(1, 16'h0000, 4'hF);
    do_op(0, 16'h0000, 4'h0);
    do_op(1, 16'hFFFF, 4'h0);
    do_op(0, 16'hFFFF, 4'h0);
    do_op(1, 16'hA55A, 4'h5);
    do_op(1, 16'hA55A, 4'hA);
    do_op(0, 16'hA55A, 4'h0);
    retention(0);
    retention(1);
    // Constrained random traffic
    for (int k = 0; k < 300; k++) begin
      bit w;
      logic [15:0] a;
      w = ($urandom % 10) < 6;
      a = {8'($urandom), 4'h0, 4'($urandom)};
      do_op(w, a, 4'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule